// File: doc/BRIEF.md
# Software-Refilled Associative Address Translator

This block translates virtual addresses to physical addresses through a small buffer of page mappings. Every slot can hold any virtual page, and a lookup compares the requested page number against all valid slots at once. On a match the physical address is the slot's frame number followed by the untranslated page-offset bits. Each hit is also checked against the slot's access rights for the requested kind of access: fetch, read or write. The block never walks a page table. When nothing matches, it reports a miss, and software installs the mapping by writing a slot of its choosing through a plain write port.

Lookups flow through a valid/ready request channel and a valid/ready response channel, with one register stage between them. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the following cycle. The response stays on the outputs, unchanged, until a cycle with `resp_ready` high. While a response is waiting, `req_ready` is low, so a stalled consumer halts the request channel. A parameter selects whether an instance serves instruction fetch or data access. One instance of each kind is expected. A kernel-mode request bypasses translation entirely.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `resp_valid` is 0, `req_ready` is 1, and every slot is invalid, so a first lookup of any page reports status MISS (code 1).
- R2: A read of a page held by a valid, resident slot whose read right is set returns status HIT (code 0). The returned `resp_pa` is {slot frame, request offset bits}. The response is presented on the cycle after the request is accepted.
- R3: A lookup whose page number matches no valid slot returns status MISS (code 1) with `resp_pa` = 0. A slot written with its valid bit at 0 no longer matches.
- R4: A matching valid slot whose resident bit is 0 returns status PAGE_FAULT (code 2) regardless of its rights. Residency is judged before rights.
- R5: The rights field is bit 0 read, bit 1 write and bit 2 execute. Access code 1 (read) needs bit 0 and code 2 (write) needs bit 1. Access code 3 is never allowed. A resident hit without the needed right returns status VIOLATION (code 3) with `resp_pa` = 0.
- R6: In the data role (FETCH_ROLE = 0), access code 0 (fetch) always returns VIOLATION on a resident hit, even with bit 2 set. In the fetch role, only code 0 is allowed, and it needs bit 2.
- R7: A request with `req_kern` high returns HIT with `resp_pa` equal to `req_va` and `resp_multi` = 0. This holds whatever the slots contain.
- R8: When several valid slots match, the lowest-numbered one supplies frame, residency and rights, and `resp_multi` is 1. With a single match, `resp_multi` is 0.
- R9: A slot write takes effect at the clock edge where `wr_en` is high. A lookup accepted on that same edge sees the slot's previous contents.
- R10: While `resp_valid` is high and `resp_ready` is low, the response outputs hold steady and `req_ready` is 0. `req_ready` is 1 whenever `resp_valid` is low or `resp_ready` is high.
- R11: Every slot index from 0 to ENTRIES-1 can hold a mapping. Each mapping is found independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one slot this cycle |
| wr_idx | input | $clog2(ENTRIES) | Slot to write |
| wr_valid | input | 1 | Valid bit for the written slot |
| wr_resident | input | 1 | Page is resident in memory |
| wr_vpn | input | VA_W-OFF_W | Virtual page number |
| wr_pfn | input | PA_W-OFF_W | Physical frame number |
| wr_perm | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_va | input | VA_W | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 reserved |
| req_kern | input | 1 | Kernel mode: bypass translation and checks |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Consumer takes the response |
| resp_pa | output | PA_W | Translated physical address |
| resp_status | output | 2 | 0 hit, 1 miss, 2 page fault, 3 violation |
| resp_multi | output | 1 | More than one valid slot matched |

## Verification
Some properties are checked on every cycle. The response is held stable under back-pressure. An accepted request always produces a response. The kernel bypass returns the address unchanged. A translated hit keeps its offset bits. The selected slot is at most one, and always one of the matching slots. The multi-match flag agrees with the number of matches. A write lands in its slot on the next edge. Scenarios in the bench cover the rest: the exact frame returned, the ordering of miss against page fault against violation, the role's rule on fetches, lowest-index priority with duplicate pages, and lookups that see a slot's old contents when a write shares their edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_HIT   = 2'd0,
    ST_MISS  = 2'd1,
    ST_FAULT = 2'd2,
    ST_VIOL  = 2'd3
  } stat_e;

  localparam int PERM_W = 3;
  localparam int PERM_R = 0;
  localparam int PERM_W_BIT = 1;
  localparam int PERM_X = 2;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 19,
  parameter int PFN_W   = 19,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic                      wr_valid,
  input  logic                      wr_resident,
  input  logic [VPN_W-1:0]          wr_vpn,
  input  logic [PFN_W-1:0]          wr_pfn,
  input  logic [tlb_pkg::PERM_W-1:0] wr_perm,
  output logic [ENTRIES-1:0]        slot_valid,
  output logic [ENTRIES-1:0]        slot_res,
  output logic [VPN_W-1:0]          slot_vpn  [ENTRIES],
  output logic [PFN_W-1:0]          slot_pfn  [ENTRIES],
  output logic [tlb_pkg::PERM_W-1:0] slot_perm [ENTRIES]
);
  logic [ENTRIES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic                       res_q;
    logic [VPN_W-1:0]           vpn_q;
    logic [PFN_W-1:0]           pfn_q;
    logic [tlb_pkg::PERM_W-1:0] perm_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q  <= 1'b0;
        vpn_q  <= '0;
        pfn_q  <= '0;
        perm_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        res_q  <= wr_resident;
        vpn_q  <= wr_vpn;
        pfn_q  <= wr_pfn;
        perm_q <= wr_perm;
      end
    end

    assign slot_res[i]  = res_q;
    assign slot_vpn[i]  = vpn_q;
    assign slot_pfn[i]  = pfn_q;
    assign slot_perm[i] = perm_q;
  end

  assign slot_valid = valid_q;

  // R9: a write is visible in its slot on the following edge
  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (slot_valid[$past(wr_idx)] == $past(wr_valid)) &&
              (slot_vpn[$past(wr_idx)] == $past(wr_vpn)));
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 19,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] slot_valid,
  input  logic [VPN_W-1:0]   slot_vpn [ENTRIES],
  input  logic [VPN_W-1:0]   look_vpn,
  output logic               any_hit,
  output logic               multi_hit,
  output logic [IDX_W-1:0]   hit_idx
);
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] sel_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = slot_valid[i] && (slot_vpn[i] == look_vpn);
  end

  // lowest index wins: isolate the least significant set bit
  assign sel_vec   = match_vec & (~match_vec + ENTRIES'(1));
  assign any_hit   = |match_vec;
  assign multi_hit = |(match_vec & (match_vec - ENTRIES'(1)));

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  // R8: at most one selected slot, and it is a matching one
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec) && ((sel_vec & ~match_vec) == '0));
  // R8: multi flag agrees with number of matching slots
  p_multi_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit == ($countones(match_vec) > 1));
  // R8: the encoded index points at the isolated lowest match
  p_idx_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> sel_vec[hit_idx]);
endmodule

// File: rtl/tlb_rights.sv
module tlb_rights #(
  parameter bit FETCH_ROLE = 1'b0
) (
  input  logic                       kern,
  input  logic                       hit,
  input  logic                       resident,
  input  logic [tlb_pkg::PERM_W-1:0] perm,
  input  tlb_pkg::acc_e              acc,
  output tlb_pkg::stat_e             status
);
  import tlb_pkg::*;

  logic allowed;

  if (FETCH_ROLE) begin : g_fetch_role
    always_comb allowed = (acc == ACC_FETCH) && perm[PERM_X];
  end else begin : g_data_role
    always_comb begin
      unique case (acc)
        ACC_READ:  allowed = perm[PERM_R];
        ACC_WRITE: allowed = perm[PERM_W_BIT];
        default:   allowed = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (kern)           status = ST_HIT;
    else if (!hit)      status = ST_MISS;
    else if (!resident) status = ST_FAULT;
    else if (allowed)   status = ST_HIT;
    else                status = ST_VIOL;
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES    = 16,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int OFF_W      = 13,
  parameter bit FETCH_ROLE = 1'b0,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int PFN_W     = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_resident,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic [2:0]       wr_perm,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_acc,
  input  logic             req_kern,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [PA_W-1:0]  resp_pa,
  output logic [1:0]       resp_status,
  output logic             resp_multi
);
  import tlb_pkg::*;

  logic [ENTRIES-1:0] slot_valid;
  logic [ENTRIES-1:0] slot_res;
  logic [VPN_W-1:0]   slot_vpn  [ENTRIES];
  logic [PFN_W-1:0]   slot_pfn  [ENTRIES];
  logic [PERM_W-1:0]  slot_perm [ENTRIES];

  logic               any_hit;
  logic               multi_hit;
  logic [IDX_W-1:0]   hit_idx;
  stat_e              stat_c;
  logic [PA_W-1:0]    pa_c;
  logic               multi_c;
  logic               accept;

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_valid   (wr_valid),
    .wr_resident(wr_resident),
    .wr_vpn     (wr_vpn),
    .wr_pfn     (wr_pfn),
    .wr_perm    (wr_perm),
    .slot_valid (slot_valid),
    .slot_res   (slot_res),
    .slot_vpn   (slot_vpn),
    .slot_pfn   (slot_pfn),
    .slot_perm  (slot_perm)
  );

  tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W)
  ) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_valid(slot_valid),
    .slot_vpn  (slot_vpn),
    .look_vpn  (req_va[VA_W-1:OFF_W]),
    .any_hit   (any_hit),
    .multi_hit (multi_hit),
    .hit_idx   (hit_idx)
  );

  tlb_rights #(
    .FETCH_ROLE(FETCH_ROLE)
  ) u_rights (
    .kern    (req_kern),
    .hit     (any_hit),
    .resident(slot_res[hit_idx]),
    .perm    (slot_perm[hit_idx]),
    .acc     (acc_e'(req_acc)),
    .status  (stat_c)
  );

  always_comb begin
    if (req_kern) begin
      pa_c    = PA_W'(req_va);
      multi_c = 1'b0;
    end else begin
      pa_c    = (stat_c == ST_HIT) ? {slot_pfn[hit_idx], req_va[OFF_W-1:0]} : '0;
      multi_c = multi_hit;
    end
  end

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_pa     <= '0;
      resp_status <= ST_HIT;
      resp_multi  <= 1'b0;
    end else if (accept) begin
      resp_valid  <= 1'b1;
      resp_pa     <= pa_c;
      resp_status <= stat_c;
      resp_multi  <= multi_c;
    end else if (resp_ready) begin
      resp_valid  <= 1'b0;
    end
  end

  // R10: a stalled response holds its contents
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> resp_valid && $stable(resp_pa) &&
                                     $stable(resp_status) && $stable(resp_multi));
  // R2: every accepted request yields a response on the next cycle
  p_accept_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);
  // R7: kernel requests pass the address through untouched
  p_kern_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kern) |=>
      (resp_pa == PA_W'($past(req_va))) && (resp_status == ST_HIT) && !resp_multi);
  // R2: translated hits keep the page-offset bits
  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (resp_status != ST_HIT) || (resp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])));
endmodule

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
  localparam int N   = 16;
  localparam int OFF = 13;
  localparam int VW  = 32 - OFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic wr_valid = 1'b0, wr_resident = 1'b0;
  logic [VW-1:0] wr_vpn = '0, wr_pfn = '0;
  logic [2:0] wr_perm = '0;
  logic req_valid = 1'b0, req_kern = 1'b0, resp_ready = 1'b1;
  logic [31:0] req_va = '0;
  logic [1:0] req_acc = '0;
  logic req_ready, resp_valid, resp_multi;
  logic [31:0] resp_pa;
  logic [1:0] resp_status;

  int n_chk = 0, n_bad = 0;

  logic          m_valid [N];
  logic          m_res   [N];
  logic [VW-1:0] m_vpn   [N];
  logic [VW-1:0] m_pfn   [N];
  logic [2:0]    m_perm  [N];

  always #5 clk = ~clk;

  tlb_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_resident(wr_resident), .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .wr_perm(wr_perm),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_acc(req_acc),
    .req_kern(req_kern), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_pa(resp_pa), .resp_status(resp_status), .resp_multi(resp_multi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model built from the requirements
  function automatic void model(input logic [31:0] va, input logic [1:0] acc, input logic kern,
                                output logic [1:0] st, output logic [31:0] pa, output logic mu);
    int sel = -1, cnt = 0;
    logic ok;
    if (kern) begin
      st = 2'd0; pa = va; mu = 1'b0; return;
    end
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == va[31:OFF]) begin
        if (sel < 0) sel = i;
        cnt++;
      end
    mu = (cnt > 1);
    pa = '0;
    if (sel < 0) st = 2'd1;
    else if (!m_res[sel]) st = 2'd2;
    else begin
      ok = (acc == 2'd1) ? m_perm[sel][0] : (acc == 2'd2) ? m_perm[sel][1] : 1'b0;
      st = ok ? 2'd0 : 2'd3;
      if (ok) pa = {m_pfn[sel], va[OFF-1:0]};
    end
  endfunction

  task automatic wr(input int idx, input logic v, input logic r, input logic [VW-1:0] vpn,
                    input logic [VW-1:0] pfn, input logic [2:0] perm);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx[3:0]; wr_valid = v; wr_resident = r;
    wr_vpn = vpn; wr_pfn = pfn; wr_perm = perm;
    @(posedge clk);
    m_valid[idx] = v; m_res[idx] = r; m_vpn[idx] = vpn; m_pfn[idx] = pfn; m_perm[idx] = perm;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] acc, input logic kern,
                      input string req);
    logic [1:0] est; logic [31:0] epa; logic emu;
    model(va, acc, kern, est, epa, emu);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc; req_kern = kern; resp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, {31'b0, resp_valid}, 32'd1);
    chk({req, " status"}, {30'b0, resp_status}, {30'b0, est});
    chk({req, " pa"}, resp_pa, epa);
    chk({req, " multi"}, {31'b0, resp_multi}, {31'b0, emu});
  endtask

  function automatic logic [31:0] va_of(input logic [VW-1:0] vpn, input logic [OFF-1:0] off);
    return {vpn, off};
  endfunction

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] hp; logic [1:0] hs; logic hm;
    void'($urandom(32'd24681));
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_res[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_perm[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 resp_valid after reset", {31'b0, resp_valid}, 32'd0);
    chk("R1 req_ready after reset", {31'b0, req_ready}, 32'd1);
    look(32'h0000_2000, 2'd1, 1'b0, "R1 first lookup misses");

    for (int i = 0; i < N; i++) wr(i, 1, 1, VW'(32'h40 + i), VW'(32'h7000 + i), 3'b111);
    for (int i = 0; i < N; i++) look(va_of(VW'(32'h40 + i), 13'h0A5 + 13'(i)), 2'd1, 1'b0, "R11 R2 slot hit");

    wr(3, 1, 1, VW'(32'h43), VW'(32'h7003), 3'b001);
    look(va_of(VW'(32'h43), 13'h10), 2'd1, 1'b0, "R5 read-only read");
    look(va_of(VW'(32'h43), 13'h10), 2'd2, 1'b0, "R5 write without right");
    look(va_of(VW'(32'h40), 13'h10), 2'd3, 1'b0, "R5 reserved access");
    wr(4, 1, 1, VW'(32'h44), VW'(32'h7004), 3'b100);
    look(va_of(VW'(32'h44), 13'h20), 2'd1, 1'b0, "R5 exec-only read");
    look(va_of(VW'(32'h44), 13'h20), 2'd0, 1'b0, "R6 fetch in data role");
    look(va_of(VW'(32'h41), 13'h20), 2'd0, 1'b0, "R6 fetch with all rights");

    wr(5, 1, 0, VW'(32'h45), VW'(32'h7005), 3'b000);
    look(va_of(VW'(32'h45), 13'h30), 2'd1, 1'b0, "R4 non-resident page fault");
    wr(6, 0, 1, VW'(32'h46), VW'(32'h7006), 3'b111);
    look(va_of(VW'(32'h46), 13'h30), 2'd1, 1'b0, "R3 invalidated slot misses");

    wr(9, 1, 1, VW'(32'h42), VW'(32'h1234), 3'b111);
    look(va_of(VW'(32'h42), 13'h44), 2'd2, 1'b0, "R8 duplicate lowest wins");
    wr(2, 0, 1, VW'(32'h42), VW'(32'h7002), 3'b111);
    look(va_of(VW'(32'h42), 13'h44), 2'd2, 1'b0, "R8 single match after invalidate");

    look(32'hDEAD_BEEF, 2'd2, 1'b1, "R7 kernel bypass");
    look(va_of(VW'(32'h45), 13'h1), 2'd3, 1'b1, "R7 kernel ignores fault");

    // R9: write and lookup on the same edge
    model(va_of(VW'(32'h47), 13'h55), 2'd1, 1'b0, hs, hp, hm);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd7; wr_valid = 1'b1; wr_resident = 1'b1;
    wr_vpn = VW'(32'h47); wr_pfn = VW'(32'h5555); wr_perm = 3'b111;
    req_valid = 1'b1; req_va = va_of(VW'(32'h47), 13'h55); req_acc = 2'd1; req_kern = 1'b0;
    @(posedge clk);
    m_pfn[7] = VW'(32'h5555); m_perm[7] = 3'b111;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R9 same-edge lookup sees old frame", resp_pa, hp);
    look(va_of(VW'(32'h47), 13'h55), 2'd1, 1'b0, "R9 later lookup sees new frame");

    // R10: back-pressure
    model(va_of(VW'(32'h48), 13'h66), 2'd1, 1'b0, hs, hp, hm);
    @(negedge clk);
    req_valid = 1'b1; req_va = va_of(VW'(32'h48), 13'h66); req_acc = 2'd1; resp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_va = va_of(VW'(32'h49), 13'h0);
    wr_en = 1'b1; wr_idx = 4'd8; wr_valid = 1'b1; wr_resident = 1'b1;
    wr_vpn = VW'(32'h48); wr_pfn = VW'(32'h2222); wr_perm = 3'b111;
    @(posedge clk);
    m_pfn[8] = VW'(32'h2222);
    @(negedge clk);
    wr_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R10 held valid", {31'b0, resp_valid}, 32'd1);
      chk("R10 req_ready low", {31'b0, req_ready}, 32'd0);
      chk("R10 held pa", resp_pa, hp);
      @(negedge clk);
    end
    req_valid = 1'b0; resp_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", {31'b0, resp_valid}, 32'd0);
    chk("R10 ready when idle", {31'b0, req_ready}, 32'd1);

    for (int it = 0; it < 400; it++) begin
      if ($urandom % 4 == 0)
        wr(int'($urandom % N), ($urandom % 5) != 0, ($urandom % 6) != 0,
           VW'(32'h100 + $urandom % 8), VW'($urandom), 3'($urandom));
      else
        look(va_of(VW'(32'h100 + $urandom % 8), 13'($urandom)), 2'($urandom),
             ($urandom % 8) == 0, "R2 R3 R4 R5 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule